// File: doc/BRIEF.md
# Arbitrated Host Write-Port Controller

This block sits between an external processor and a shared storage area made of a RAM and a register file. The processor starts a write by pulling select and strobe low. These two inputs need not be synchronous to the local clock. The controller answers with an active-low acknowledge, `ioen_n`, once the internal protocol engine is not claiming the RAM. It captures the target kind and the direction on the next falling clock edge, and the address and data on a following rising edge. It then issues a one-clock write strobe to the chosen target and drives the active-low completion flag `readyd_n`. The cycle closes when the host raises strobe again.

A request that arrives late in the clock period is detected by a falling-edge pre-sampler. In that case one extra clock is inserted between the control capture and the address/data capture, and completion comes one clock later. The sequencer has the states IDLE, GRANT, EXTRA, HOLD, WSTB and DONE. The transitions are:

- IDLE→GRANT when the controller is armed, select and strobe are low, and the protocol side is not busy.
- GRANT→HOLD for a normal request.
- GRANT→EXTRA for a late request, followed by EXTRA→HOLD.
- HOLD→WSTB.
- WSTB→DONE.
- DONE→IDLE once strobe is sampled high.

Top module: `hostwr_port_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block goes to this state: `ioen_n` and `readyd_n` are 1, `ram_we` and `reg_we` are 0, and `wr_addr` and `wr_data` are 0.
- R2: `ioen_n` goes low after the first rising edge at which `sel_n` and `strb_n` are both 0, the block is armed, and `int_busy` is 0. After that edge, `sel_n` may return to 1 without ending the cycle.
- R3: A rising edge that samples `int_busy` = 1 grants nothing, and `ioen_n` stays 1. The pending host request is granted at the first edge that samples `int_busy` = 0.
- R4: `mem_regn` is captured at the first falling edge after the grant, and later changes have no effect. A value of 1 targets the RAM (`ram_we`), and a value of 0 targets the register file (`reg_we`). The two strobes are never high together.
- R5: `rd_wrn` is captured at that same falling edge. When `wpol` = 1, `rd_wrn` = 0 means write. When `wpol` = 0, `rd_wrn` = 1 means write. For a non-write cycle, no write strobe is issued, but `readyd_n` still completes.
- R6: For a normal request, `addr` and `data` are captured at the first rising edge after the grant edge. Changes after that edge do not alter `wr_addr` and `wr_data`.
- R7: A request is late when the falling edge just before the grant edge saw select and strobe not both low. For a late request, the capture moves one rising edge later, and every later event also shifts by one clock.
- R8: Let C be the capture edge. The write strobe is high for exactly the clock after edge C+1, and `readyd_n` goes low after edge C+2.
- R9: `readyd_n` and `ioen_n` stay low while `strb_n` is sampled 0. Both return to 1 after the first rising edge that samples `strb_n` = 1.
- R10: After reset, no grant happens until `strb_n` has been sampled 1 at a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Host select, active low |
| strb_n | input | 1 | Host strobe, active low |
| mem_regn | input | 1 | 1 selects RAM, 0 selects register file |
| rd_wrn | input | 1 | Direction, sense set by `wpol` |
| wpol | input | 1 | Write-polarity configuration |
| addr | input | ADDR_W | Host address |
| data | input | DATA_W | Host write data |
| int_busy | input | 1 | Internal protocol logic holds the RAM |
| ioen_n | output | 1 | Access acknowledge, active low |
| readyd_n | output | 1 | Completion flag, active low |
| ram_we | output | 1 | One-clock RAM write strobe |
| reg_we | output | 1 | One-clock register write strobe |
| wr_addr | output | ADDR_W | Captured address |
| wr_data | output | DATA_W | Captured data |

## Verification
The embedded properties watch four things on every clock:

- arbitration blocking while the protocol side is busy;
- the exclusiveness of the two write strobes;
- completion following the strobe by one clock, and its hold-and-release against `strb_n`;
- stability of the captured address during the strobe.

The bench sweeps the following combinations:

- target kind, direction, polarity and request timing;
- with and without an arbitration stall.

In each scenario the bench moves the control, address and data inputs just before and just after their capture edges. Only these scenarios can show the exact capture points, the one-clock late-request shift, and the arming rule after reset.

// File: rtl/hostwr_pkg.sv
package hostwr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GRANT = 3'd1,
        ST_EXTRA = 3'd2,
        ST_HOLD  = 3'd3,
        ST_WSTB  = 3'd4,
        ST_DONE  = 3'd5
    } hw_state_e;
endpackage

// File: rtl/hostwr_presample.sv
// Falling-edge view of the host request, used to tell a late request apart.
module hostwr_presample (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic req_early
);
    always_ff @(negedge clk) begin
        if (!rst_n) req_early <= 1'b0;
        else        req_early <= req;
    end
endmodule

// File: rtl/hostwr_capture.sv
// Control capture on the falling edge, address/data capture on the rising edge.
module hostwr_capture #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_cap,
    input  logic              ad_cap,
    input  logic              mem_regn,
    input  logic              rd_wrn,
    input  logic              wpol,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              is_mem,
    output logic              is_wr,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    logic wr_now;
    assign wr_now = wpol ? ~rd_wrn : rd_wrn;

    always_ff @(negedge clk) begin
        if (!rst_n) begin
            is_mem <= 1'b0;
            is_wr  <= 1'b0;
        end else if (ctrl_cap) begin
            is_mem <= mem_regn;
            is_wr  <= wr_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (ad_cap) begin
            addr_q <= addr;
            data_q <= data;
        end
    end

    AST_AD_ONLY_ON_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ad_cap && $past(rst_n)) |=> $stable(addr_q)); // R6
endmodule

// File: rtl/hostwr_fsm.sv
module hostwr_fsm
    import hostwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_early,
    input  logic strb_n,
    input  logic int_busy,
    input  logic is_mem,
    input  logic is_wr,
    output logic ctrl_cap,
    output logic ad_cap,
    output logic ioen_n,
    output logic readyd_n,
    output logic ram_we,
    output logic reg_we
);
    hw_state_e state, nxt;
    logic      late_q;
    logic      armed;
    logic      grant;

    assign grant = armed && req && !int_busy;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (grant) nxt = ST_GRANT;
            ST_GRANT: nxt = late_q ? ST_EXTRA : ST_HOLD;
            ST_EXTRA: nxt = ST_HOLD;
            ST_HOLD:  nxt = ST_WSTB;
            ST_WSTB:  nxt = ST_DONE;
            ST_DONE:  if (strb_n) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            late_q <= 1'b0;
            armed  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && grant) begin
                late_q <= ~req_early;
                armed  <= 1'b0;
            end else if (strb_n) begin
                armed <= 1'b1;
            end
        end
    end

    always_comb begin
        ioen_n   = (state == ST_IDLE);
        readyd_n = (state != ST_DONE);
        ctrl_cap = (state == ST_GRANT);
        ad_cap   = ((state == ST_GRANT) && !late_q) || (state == ST_EXTRA);
        ram_we   = (state == ST_WSTB) && is_wr && is_mem;
        reg_we   = (state == ST_WSTB) && is_wr && !is_mem;
    end

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ioen_n && int_busy) |=> ioen_n); // R3
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!readyd_n && !strb_n) |=> (!readyd_n && !ioen_n)); // R9
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!readyd_n && strb_n) |=> (readyd_n && ioen_n)); // R9
endmodule

// File: rtl/hostwr_port_ctrl.sv
module hostwr_port_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              strb_n,
    input  logic              mem_regn,
    input  logic              rd_wrn,
    input  logic              wpol,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              int_busy,
    output logic              ioen_n,
    output logic              readyd_n,
    output logic              ram_we,
    output logic              reg_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic req, req_early, ctrl_cap, ad_cap, is_mem, is_wr;

    assign req = ~sel_n & ~strb_n;

    hostwr_presample u_pre (
        .clk(clk), .rst_n(rst_n), .req(req), .req_early(req_early)
    );

    hostwr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .ctrl_cap(ctrl_cap), .ad_cap(ad_cap),
        .mem_regn(mem_regn), .rd_wrn(rd_wrn), .wpol(wpol),
        .addr(addr), .data(data), .is_mem(is_mem), .is_wr(is_wr),
        .addr_q(wr_addr), .data_q(wr_data)
    );

    hostwr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .req_early(req_early),
        .strb_n(strb_n), .int_busy(int_busy), .is_mem(is_mem), .is_wr(is_wr),
        .ctrl_cap(ctrl_cap), .ad_cap(ad_cap), .ioen_n(ioen_n),
        .readyd_n(readyd_n), .ram_we(ram_we), .reg_we(reg_we)
    );

    AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && reg_we)); // R4
    AST_READY_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || reg_we) |=> !readyd_n); // R8
    AST_ADDR_HELD_IN_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || reg_we) |-> ($stable(wr_addr) && $stable(wr_data))); // R6
    AST_READY_INSIDE_IOEN: assert property (@(posedge clk) disable iff (!rst_n)
        !readyd_n |-> !ioen_n); // R9
endmodule

// File: tb/hostwr_port_ctrl_tb.sv
`timescale 1ns/100ps
module hostwr_port_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b0, strb_n = 1'b0, mem_regn = 1'b0, rd_wrn = 1'b0, wpol = 1'b0;
    logic [15:0] addr = '0, data = '0;
    logic int_busy = 1'b0;
    logic ioen_n, readyd_n, ram_we, reg_we;
    logic [15:0] wr_addr, wr_data;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    hostwr_port_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strb_n(strb_n),
        .mem_regn(mem_regn), .rd_wrn(rd_wrn), .wpol(wpol), .addr(addr),
        .data(data), .int_busy(int_busy), .ioen_n(ioen_n), .readyd_n(readyd_n),
        .ram_we(ram_we), .reg_we(reg_we), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One host write: busy = stall clocks, late = request after the falling edge
    task automatic run_wr(input bit late, input int busy, input bit mem,
                          input bit pol, input bit rw, input logic [15:0] a,
                          input logic [15:0] d);
        bit lt;
        bit wr;
        lt = late && (busy == 0);
        wr = pol ? !rw : rw;
        wpol = pol;
        @(posedge clk);
        #1;
        int_busy = (busy > 0);
        mem_regn = !mem; rd_wrn = !rw;
        addr = ~a; data = ~d;
        if (late) #2.5;
        sel_n = 1'b0; strb_n = 1'b0;
        for (int i = 0; i <= busy + 6 + lt; i++) begin
            @(posedge clk);
            #2;
            chk($sformatf("R2/R3/R7 ioen i=%0d", i), ioen_n,
                !(i >= busy && i <= busy + 4 + lt));
            chk($sformatf("R8/R9 readyd i=%0d", i), readyd_n,
                !(i >= busy + 3 + lt && i <= busy + 4 + lt));
            chk($sformatf("R4/R5/R8 ram_we i=%0d", i), ram_we,
                (i == busy + 2 + lt) && wr && mem);
            chk($sformatf("R4/R5/R8 reg_we i=%0d", i), reg_we,
                (i == busy + 2 + lt) && wr && !mem);
            if (i == busy + 2 + lt) begin
                chk("R6/R7 wr_addr", wr_addr, a);
                chk("R6/R7 wr_data", wr_data, d);
            end
            #0.1;
            if (busy > 0 && i == busy - 1) int_busy = 1'b0;
            if (i == busy) begin
                sel_n = 1'b1;
                mem_regn = mem; rd_wrn = rw;
            end
            if (i == busy + 1) begin
                mem_regn = !mem; rd_wrn = !rw;
            end
            if (i == busy + lt) begin
                addr = a; data = d;
            end
            if (i == busy + 1 + lt) begin
                addr = a ^ 16'h5A5A; data = d ^ 16'hA5A5;
            end
            if (i == busy + 4 + lt) strb_n = 1'b1;
        end
        sel_n = 1'b1; strb_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 ioen", ioen_n, 1); chk("R1 readyd", readyd_n, 1);
        chk("R1 ram_we", ram_we, 0); chk("R1 reg_we", reg_we, 0);
        chk("R1 wr_addr", wr_addr, 0); chk("R1 wr_data", wr_data, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk("R10 no grant before strobe high", ioen_n, 1);
        sel_n = 1'b1; strb_n = 1'b1;
        repeat (2) @(posedge clk);
        for (int k = 0; k < 32; k++) begin
            run_wr(k[0], k[1] ? 2 : 0, k[2], k[3], k[4],
                   16'h1000 + 16'(k * 37), 16'hC000 ^ 16'(k * 113));
            repeat (2) @(posedge clk);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule